// File: doc/BRIEF.md
# Iteration Lockstep Sync Node

This block sits in every node of a two-dimensional array of compute nodes and keeps all of them in step, one stencil iteration at a time. Exactly one node is strapped as the master. The master runs a local beacon timer with a period of `alpha + beta` cycles. `alpha` is the length of one iteration. `beta` is a slack margin that absorbs clock drift between nodes. At each beacon the master enables its own compute engine for one iteration and sends a sync pulse to its left and lower neighbours.

Every other node keeps its compute engine stalled until a sync pulse arrives on its input. The input passes through a two-flop synchroniser and a deglitch filter, which accepts only a level that stays high for `FILT` consecutive samples. Once a pulse is accepted, the node releases its engine for exactly `alpha` cycles. In the same cycle it starts a `FILT`-cycle sync pulse towards its own left and lower neighbours, so the wave spreads across the array.

A sync that arrives while an iteration is still running is not queued. It raises a sticky overrun flag. A sync that lands on the final cycle of an iteration starts the next iteration directly, so the enable stays high across the boundary.

The node's controller is a two-state machine:
- States: `ST_WAIT` (stalled) and `ST_RUN` (computing).
- Transitions:
  - WAIT→RUN on start.
  - RUN→RUN on a decrement, or on a start in the final cycle (restart).
  - RUN→WAIT at the end of the count.
  - RUN→RUN with the overrun flag set when a start arrives early.

Top module: `sync_chain_node`

## Requirements
- R1: During and after reset, `compute_en`, `sync_left`, `sync_down` and `overrun` are 0. A non-master node with `sync_in` held low keeps `compute_en` at 0 indefinitely. Reset clears `overrun`.
- R2: A non-master node accepts `sync_in` only after the synchronised level has been high for `FILT` consecutive clock samples. A pulse of `FILT-1` cycles has no effect on any output.
- R3: A high level held for any length yields exactly one accepted sync. A later pulse, after the iteration has ended, starts a new iteration.
- R4: On a non-master node, `compute_en` goes high at the `FILT+2`-th rising edge after the first rising edge that samples `sync_in` high.
- R5: Each iteration holds `compute_en` high for exactly `alpha` cycles. `alpha` is sampled at the start, and a value of 0 is treated as 1. After the iteration, `compute_en` is 0 until the next start.
- R6: `sync_left` and `sync_down` rise together with `compute_en` at each start. Both stay high for `FILT` cycles and are always equal.
- R7: A master node (`is_master`=1) ignores `sync_in`. It starts an iteration on the first clock edge after reset and then every `alpha+beta` cycles.
- R8: A start while running, other than in the iteration's last cycle, sets `overrun` to 1 until reset. It neither extends the run, nor queues a new one, nor forwards a pulse.
- R9: A start in the last cycle of an iteration begins a new iteration at once, without setting `overrun`. With `beta`=0 the master holds `compute_en` high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | Strap: 1 makes this node the beacon source |
| sync_in | input | 1 | Sync pulse from the upstream neighbour (asynchronous) |
| alpha | input | CW | Iteration length in cycles |
| beta | input | CW | Skew margin in cycles added to the beacon period |
| sync_left | output | 1 | Forwarded sync to the left neighbour |
| sync_down | output | 1 | Forwarded sync to the lower neighbour |
| compute_en | output | 1 | Releases the compute engine for the current iteration |
| overrun | output | 1 | Sticky flag: sync arrived before the iteration finished |

## Verification
Two events can coincide: the final cycle of an iteration and the arrival of a new start. The run-length counter decides whether this is a legal restart or an overrun.

The coincidence is provoked on the master with `beta`=0, where each beacon lands exactly on the last run cycle. The bench then judges that `compute_en` never drops, that forwarding repeats once per period, and that `overrun` stays 0.

A second sync is also injected into a non-master halfway through a long iteration. There the bench expects the flag to set while the enable count stays at `alpha` and only one rising edge of `compute_en` appears.

// File: rtl/sync_chain_pkg.sv
package sync_chain_pkg;
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } node_state_t;
endpackage

// File: rtl/sync_deglitch.sv
// Synchroniser plus stable-high filter; emits one accept pulse per high level.
module sync_deglitch #(
    parameter int FILT   = 3,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic accept_o
);
    localparam int HW = $clog2(FILT + 1);

    logic [STAGES-1:0] sync_sh;
    logic              lvl;
    logic [HW-1:0]     hi_cnt;

    assign lvl = sync_sh[STAGES-1];

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sh <= '0;
                else        sync_sh <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sh <= '0;
                else        sync_sh <= {sync_sh[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            accept_o <= 1'b0;
        end else begin
            accept_o <= lvl && (hi_cnt == HW'(FILT - 1));
            if (!lvl)                        hi_cnt <= '0;
            else if (hi_cnt != HW'(FILT))    hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R3: an accept is a single-cycle pulse
    p_accept_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);
    // R2: an accept is only produced while the synchronised level is high
    p_accept_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(lvl));
endmodule

// File: rtl/beacon_timer.sv
// Master beacon: one pulse every alpha+beta cycles, starting at the first edge.
module beacon_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic [CW-1:0] alpha_i,
    input  logic [CW-1:0] beta_i,
    output logic          beacon_o
);
    localparam int PW = CW + 1;

    logic [PW-1:0] period;
    logic [PW-1:0] tmr;
    logic [PW-1:0] tmr_inc;

    assign period   = {1'b0, alpha_i} + {1'b0, beta_i};
    assign tmr_inc  = tmr + PW'(1);
    assign beacon_o = enable_i && (tmr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              tmr <= '0;
        else if (!enable_i)      tmr <= '0;
        else if (tmr_inc >= period) tmr <= '0;
        else                     tmr <= tmr_inc;
    end

    // R7: with a period above one, beacons never fall on adjacent cycles
    p_beacon_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beacon_o && period > PW'(1) && $stable(period)) |=> !beacon_o);
endmodule

// File: rtl/iter_fsm.sv
// Iteration controller: run window, forward pulse and overrun flag.
module iter_fsm
    import sync_chain_pkg::*;
#(
    parameter int CW    = 16,
    parameter int FWD_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] alpha_i,
    output logic          en_o,
    output logic          fwd_o,
    output logic          overrun_o
);
    localparam int FW = $clog2(FWD_W + 1);

    node_state_t   state_q, state_d;
    logic [CW-1:0] run_cnt;
    logic [FW-1:0] fwd_cnt;
    logic          last_cycle;
    logic          launch;
    logic          early;

    assign last_cycle = (state_q == ST_RUN) && (run_cnt <= CW'(1));
    assign launch     = start_i && ((state_q == ST_WAIT) || last_cycle);
    assign early      = start_i && (state_q == ST_RUN) && !last_cycle;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (last_cycle && !start_i) state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // counters and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            fwd_cnt   <= '0;
            overrun_o <= 1'b0;
        end else begin
            if (launch)
                run_cnt <= (alpha_i == '0) ? CW'(1) : alpha_i;
            else if (state_q == ST_RUN)
                run_cnt <= run_cnt - 1'b1;
            if (launch)              fwd_cnt <= FW'(FWD_W);
            else if (fwd_cnt != '0)  fwd_cnt <= fwd_cnt - 1'b1;
            if (early) overrun_o <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        en_o  = 1'b0;
        fwd_o = (fwd_cnt != '0);
        unique case (state_q)
            ST_WAIT: en_o = 1'b0;
            ST_RUN:  en_o = 1'b1;
            default: en_o = 1'b0;
        endcase
    end

    // R8: overrun is sticky until reset
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
    // R8: an early start keeps the iteration running, it does not cut it short
    p_early_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        early |=> en_o);
    // R6: forwarding starts only together with an enabled iteration
    p_fwd_with_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_o) |-> en_o);
    // R9: a start in the last cycle keeps the enable high
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && last_cycle) |=> (en_o && !$changed(overrun_o)));
endmodule

// File: rtl/sync_chain_node.sv
module sync_chain_node #(
    parameter int CW     = 16,
    parameter int FILT   = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master,
    input  logic          sync_in,
    input  logic [CW-1:0] alpha,
    input  logic [CW-1:0] beta,
    output logic          sync_left,
    output logic          sync_down,
    output logic          compute_en,
    output logic          overrun
);
    logic accept;
    logic beacon;
    logic start;
    logic fwd;

    sync_deglitch #(.FILT(FILT), .STAGES(STAGES)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (sync_in),
        .accept_o (accept)
    );

    beacon_timer #(.CW(CW)) u_beacon (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (is_master),
        .alpha_i  (alpha),
        .beta_i   (beta),
        .beacon_o (beacon)
    );

    assign start = is_master ? beacon : accept;

    iter_fsm #(.CW(CW), .FWD_W(FILT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .alpha_i   (alpha),
        .en_o      (compute_en),
        .fwd_o     (fwd),
        .overrun_o (overrun)
    );

    assign sync_left = fwd;
    assign sync_down = fwd;

    // R7: the master never reacts to the filtered input
    p_master_ignores_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && $stable(is_master) && !beacon) |=> !$rose(compute_en));
endmodule

// File: tb/sync_chain_node_tb.sv
module sync_chain_node_tb;
    localparam int CLK_P = 10;
    localparam int CW    = 16;
    localparam int FILT  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_master = 1'b0;
    logic          sync_in = 1'b0;
    logic [CW-1:0] alpha = '0;
    logic [CW-1:0] beta = '0;
    logic          sync_left, sync_down, compute_en, overrun;

    int total = 0;
    int bad   = 0;

    // window results
    int first_rise, en_cnt, rises, fwd_cnt, lr_mismatch, ovr_end;

    always #(CLK_P/2) clk = ~clk;

    sync_chain_node #(.CW(CW), .FILT(FILT)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_master  (is_master),
        .sync_in    (sync_in),
        .alpha      (alpha),
        .beta       (beta),
        .sync_left  (sync_left),
        .sync_down  (sync_down),
        .compute_en (compute_en),
        .overrun    (overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit master);
        rst_n = 1'b0;
        sync_in = 1'b0;
        is_master = master;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Sample at each negedge, then drive sync_in for the next edge.
    task automatic window(input int ncyc, input int w1, input int s2, input int w2,
                          input bit toggle_in);
        logic prev_en = 1'b0;
        first_rise = -1; en_cnt = 0; rises = 0; fwd_cnt = 0; lr_mismatch = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (compute_en) en_cnt++;
            if (compute_en && !prev_en) begin
                rises++;
                if (first_rise < 0) first_rise = i;
            end
            if (sync_left) fwd_cnt++;
            if (sync_left != sync_down) lr_mismatch++;
            if (sync_left && !compute_en) lr_mismatch++;
            prev_en = compute_en;
            if (toggle_in) sync_in = i[1];
            else sync_in = (i < w1) || (i >= s2 && i < s2 + w2);
        end
        sync_in = 1'b0;
        ovr_end = overrun;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!compute_en && !sync_left && !sync_down && !overrun, "R1 reset outputs",
            {compute_en, sync_left, sync_down, overrun}, 0);
        do_reset(1'b0);
        alpha = 16'd5;
        window(30, 0, 0, 0, 1'b0);
        chk(en_cnt == 0, "R1 stalled without sync", en_cnt, 0);
    endtask

    task automatic t_accept;
        do_reset(1'b0);
        alpha = 16'd7;
        window(6 + 7 + 6, FILT, 1000, 0, 1'b0);
        chk(first_rise == FILT + 3, "R4 enable latency", first_rise, FILT + 3);
        chk(en_cnt == 7, "R5 run length", en_cnt, 7);
        chk(rises == 1, "R5 one run", rises, 1);
        chk(fwd_cnt == FILT, "R6 forward width", fwd_cnt, FILT);
        chk(lr_mismatch == 0, "R6 left/down equal with enable", lr_mismatch, 0);
        chk(ovr_end == 0, "R8 no overrun on single sync", ovr_end, 0);
    endtask

    task automatic t_alpha_zero;
        do_reset(1'b0);
        alpha = 16'd0;
        window(16, FILT, 1000, 0, 1'b0);
        chk(en_cnt == 1, "R5 alpha zero as one", en_cnt, 1);
    endtask

    task automatic t_glitch;
        do_reset(1'b0);
        alpha = 16'd5;
        window(20, FILT - 1, 8, FILT - 1, 1'b0);
        chk(en_cnt == 0 && rises == 0, "R2 short pulse ignored (enable)", en_cnt, 0);
        chk(fwd_cnt == 0, "R2 short pulse ignored (forward)", fwd_cnt, 0);
    endtask

    task automatic t_long;
        do_reset(1'b0);
        alpha = 16'd4;
        window(40, 25, 1000, 0, 1'b0);
        chk(rises == 1 && en_cnt == 4, "R3 long level gives one run", en_cnt, 4);
        do_reset(1'b0);
        window(40, FILT, 15, FILT, 1'b0);
        chk(rises == 2 && en_cnt == 8, "R3 second pulse after run", en_cnt, 8);
        chk(ovr_end == 0, "R3 no overrun when spaced", ovr_end, 0);
    endtask

    task automatic t_overrun;
        do_reset(1'b0);
        alpha = 16'd20;
        window(40, FILT, 10, FILT, 1'b0);
        chk(ovr_end == 1, "R8 overrun set", ovr_end, 1);
        chk(en_cnt == 20 && rises == 1, "R8 run not extended or queued", en_cnt, 20);
        chk(fwd_cnt == FILT, "R8 early sync not forwarded", fwd_cnt, FILT);
        window(10, 0, 1000, 0, 1'b0);
        chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
        do_reset(1'b0);
        @(negedge clk);
        chk(overrun == 1'b0, "R1 reset clears overrun", overrun, 0);
    endtask

    task automatic t_master;
        alpha = 16'd5;
        beta  = 16'd3;
        do_reset(1'b1);
        window(24, 0, 0, 0, 1'b1);
        chk(first_rise == 0, "R7 master starts after reset", first_rise, 0);
        chk(rises == 3 && en_cnt == 15, "R7 master period alpha+beta", en_cnt, 15);
        chk(fwd_cnt == 3 * FILT, "R7 master forwards each beacon", fwd_cnt, 3 * FILT);
        chk(lr_mismatch == 0, "R6 master left/down equal", lr_mismatch, 0);
    endtask

    task automatic t_master_b0;
        alpha = 16'd5;
        beta  = 16'd0;
        do_reset(1'b1);
        window(20, 0, 0, 0, 1'b1);
        chk(rises == 1 && en_cnt == 20, "R9 continuous enable on restart", en_cnt, 20);
        chk(fwd_cnt == 4 * FILT, "R9 forward each restart", fwd_cnt, 4 * FILT);
        chk(ovr_end == 0, "R9 restart not an overrun", ovr_end, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_accept();
        t_alpha_zero();
        t_glitch();
        t_long();
        t_overrun();
        t_master();
        t_master_b0();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule